// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer with Three Modulation Inputs

The block turns a phase increment into a stream of cosine and sine samples, one pair per clock. A phase accumulator wraps modulo 2^PHASE_W. The register holding the increment feeds it, so the accumulator steps through the requested fraction of a turn on every clock. The resulting phase is mapped to two signed samples through a single quarter-wave table, which is computed at elaboration. The samples are then scaled by an amplitude word.

Each of the three modulation inputs enters the chain at its own point. The frequency offset is added to the tuning word before accumulation. The phase offset is added to the accumulator output before the table lookup. The amplitude word multiplies the looked-up samples. All four controls are captured together on a load strobe, so a retune never sees a half-written value. Every arithmetic step has its own register, which keeps the combinational paths short at clock rates of 200 MHz and above. A retune reaches the output after a fixed number of clocks.

Top module: `quad_dds`

## Requirements
- R1: The accumulator adds the effective increment on every clock and wraps modulo 2^PHASE_W. With 32 bits at a 200 MHz clock, one step of the tuning word is about 0.047 Hz.
- R2: For phase p, let n be the top LUT_AW+2 bits of p. The sample angle is 2π·(n+0.5)/2^(LUT_AW+2). `out_q` is within 1 LSB of 32767·sin(angle)·amp/65536 (default widths).
- R3: `out_i` is the cosine of that same angle, with the same scale and the same 1 LSB tolerance.
- R4: `tune`, `fm_ofs`, `pm_ofs` and `amp` are captured only on a clock edge where `load` is high. Changing them while `load` is low has no effect on the outputs.
- R5: `fm_ofs` is a signed value. It is sign-extended and added to the tuning word, and the sum is the effective increment.
- R6: `pm_ofs` is a signed value added to the top PM_W bits of the accumulator phase before the lookup. The low phase bits are left as they are.
- R7: The output is round(sample·amp/2^AMP_W), with `amp` taken as unsigned. An `amp` of zero gives outputs of exactly zero.
- R8: Suppose a new tuning word is loaded at edge L, replacing an old word that was in effect. The output after edge L+k then reflects accumulator phase acc_L + T_old + (k−5)·T_new for k ≥ 5, and continues the old tone for k < 5. The first output that shows the new word appears after L+6.
- R9: A synchronous, active-high `rst` clears the accumulator and all captured controls, drives both outputs to 0 and drops `valid`. After `rst` falls, `valid` stays low for the first three edges and goes high on the fourth edge.
- R10: While `valid` is high, both outputs stay within ±(2^(SAMP_W−1)−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the four control words |
| tune | input | PHASE_W | Tuning word: phase advance per clock |
| fm_ofs | input | FM_W | Signed frequency offset |
| pm_ofs | input | PM_W | Signed phase offset (top bits of phase) |
| amp | input | AMP_W | Unsigned amplitude scale |
| out_i | output | SAMP_W | Signed in-phase (cosine) sample |
| out_q | output | SAMP_W | Signed quadrature (sine) sample |
| valid | output | 1 | High once the pipeline has filled after reset |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 24-bit frequency offset, a 16-bit phase offset, a 64-entry quarter table and 16-bit samples and scale. With a 64-entry table, every table entry in all four quadrants is reached within a few dozen samples. A 32-bit phase lets tuning words above half a turn wrap the accumulator on almost every clock, which exercises the modular arithmetic. Because the phase offset is 16 bits wide, an offset of one quarter turn is an exact value. The bench can therefore check that offset directly against the sine and cosine it predicts.

// File: rtl/quad_dds.sv
`timescale 1ns/1ps
module quad_dds #(
  parameter int PHASE_W = 32,
  parameter int FM_W    = 24,
  parameter int PM_W    = 16,
  parameter int LUT_AW  = 6,
  parameter int SAMP_W  = 16,
  parameter int AMP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [PHASE_W-1:0]       tune,
  input  logic signed [FM_W-1:0]   fm_ofs,
  input  logic signed [PM_W-1:0]   pm_ofs,
  input  logic [AMP_W-1:0]         amp,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q,
  output logic                     valid
);
  localparam int QN     = 1 << LUT_AW;
  localparam int IDX_W  = LUT_AW + 2;
  localparam int PEAK   = (1 << (SAMP_W-1)) - 1;
  localparam int PROD_W = SAMP_W + AMP_W + 1;

  function automatic logic [SAMP_W-1:0] qsin(int k);
    real x, term, sum;
    x = 3.14159265358979 * (real'(k) + 0.5) / (2.0 * real'(QN));
    term = x;
    sum = x;
    for (int n = 1; n < 10; n++) begin
      term = -term * x * x / real'((2*n) * (2*n+1));
      sum = sum + term;
    end
    return SAMP_W'($rtoi(sum * real'(PEAK) + 0.5));
  endfunction

  logic [SAMP_W-1:0] qtab [QN];
  for (genvar k = 0; k < QN; k++) begin : g_tab
    assign qtab[k] = qsin(k);
  end

  logic [PHASE_W-1:0]       tune_r, incr_r, acc;
  logic signed [FM_W-1:0]   fm_r;
  logic signed [PM_W-1:0]   pm_r;
  logic [AMP_W-1:0]         am_r;
  logic [IDX_W-1:0]         ph_r;
  logic [1:0]               quad_r;
  logic [SAMP_W-1:0]        smag_r, cmag_r;
  logic signed [SAMP_W-1:0] sin_r, cos_r;
  logic [3:0]               vld_sr;

  logic [LUT_AW-1:0] idx, mir;
  logic [1:0]        quad;
  logic [SAMP_W-1:0] smag, cmag;
  assign idx  = ph_r[LUT_AW-1:0];
  assign mir  = ~idx;
  assign quad = ph_r[IDX_W-1 -: 2];
  assign smag = quad[0] ? qtab[mir] : qtab[idx];
  assign cmag = quad[0] ? qtab[idx] : qtab[mir];

  logic signed [PROD_W-1:0] ps, pc, rs, rc;
  localparam logic [PROD_W-1:0] HALF = {{(PROD_W-AMP_W){1'b0}}, 1'b1, {(AMP_W-1){1'b0}}};
  assign ps = sin_r * $signed({1'b0, am_r});
  assign pc = cos_r * $signed({1'b0, am_r});
  assign rs = ps + $signed(HALF);
  assign rc = pc + $signed(HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_r <= '0; fm_r <= '0; pm_r <= '0; am_r <= '0;
      incr_r <= '0; acc <= '0; ph_r <= '0;
      quad_r <= '0; smag_r <= '0; cmag_r <= '0;
      sin_r <= '0; cos_r <= '0;
      out_i <= '0; out_q <= '0; vld_sr <= '0;
    end else begin
      if (load) begin
        tune_r <= tune; fm_r <= fm_ofs; pm_r <= pm_ofs; am_r <= amp;
      end
      incr_r <= tune_r + {{(PHASE_W-FM_W){fm_r[FM_W-1]}}, fm_r};
      acc    <= acc + incr_r;
      ph_r   <= IDX_W'((acc[PHASE_W-1 -: PM_W] + pm_r) >> (PM_W-IDX_W));
      quad_r <= quad;
      smag_r <= smag;
      cmag_r <= cmag;
      sin_r  <= quad_r[1]             ? -$signed(smag_r) : $signed(smag_r);
      cos_r  <= (quad_r[1]^quad_r[0]) ? -$signed(cmag_r) : $signed(cmag_r);
      out_q  <= rs[AMP_W +: SAMP_W];
      out_i  <= rc[AMP_W +: SAMP_W];
      vld_sr <= {vld_sr[2:0], 1'b1};
    end
  end

  assign valid = vld_sr[3];
endmodule

// File: rtl/quad_dds_chk.sv
`timescale 1ns/1ps
module quad_dds_chk #(
  parameter int PHASE_W = 32,
  parameter int SAMP_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     load,
  input logic [PHASE_W-1:0]       tune_r,
  input logic [SAMP_W-1:0]        smag,
  input logic [SAMP_W-1:0]        cmag,
  input logic                     valid,
  input logic signed [SAMP_W-1:0] out_i,
  input logic signed [SAMP_W-1:0] out_q
);
  localparam int PEAK = (1 << (SAMP_W-1)) - 1;

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid && out_i == 0 && out_q == 0));

  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  // R10
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (out_i <= PEAK && out_i >= -PEAK && out_q <= PEAK && out_q >= -PEAK));

  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(tune_r));

  // R3
  quad_mag_chk: assert property (@(posedge clk) disable iff (rst)
    (smag >= SAMP_W'(PEAK/2)) || (cmag >= SAMP_W'(PEAK/2)));
endmodule

bind quad_dds quad_dds_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .tune_r(tune_r),
  .smag(smag), .cmag(cmag), .valid(valid), .out_i(out_i), .out_q(out_q));

// File: tb/quad_dds_test.sv
`timescale 1ns/1ps
module quad_dds_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1, load = 1'b0;
  logic [31:0]        tune = '0;
  logic signed [23:0] fm_ofs = '0;
  logic signed [15:0] pm_ofs = '0;
  logic [15:0]        amp = '0;
  logic signed [15:0] out_i, out_q;
  logic               valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  quad_dds uut (.clk(clk), .rst(rst), .load(load), .tune(tune), .fm_ofs(fm_ofs),
    .pm_ofs(pm_ofs), .amp(amp), .out_i(out_i), .out_q(out_q), .valid(valid));

  task automatic expect_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_near(string req, string what, int act, real exp);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d > 1.0 || d < -1.0) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0f", req, what, act, exp);
    end
  endtask

  task automatic check_phase(string req, logic [31:0] ph, logic [15:0] a);
    real ang, sc;
    ang = 6.283185307179586 * (real'(ph[31:24]) + 0.5) / 256.0;
    sc  = 32767.0 * real'(a) / 65536.0;
    expect_near({req, "/R2"}, "out_q", out_q, sc * $sin(ang));
    expect_near({req, "/R3"}, "out_i", out_i, sc * $cos(ang));
    expect_int({req, "/R10"}, "range", int'(out_i >= -32767 && out_q >= -32767), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; load = 1'b0;
    tune = '0; fm_ofs = '0; pm_ofs = '0; amp = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_reset_valid();
    do_reset();
    rst = 1'b1;
    @(negedge clk);
    expect_int("R9", "valid in reset", int'(valid), 0);
    expect_int("R9", "out_i in reset", out_i, 0);
    expect_int("R9", "out_q in reset", out_q, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    expect_int("R9", "valid after 3 edges", int'(valid), 0);
    @(negedge clk);
    expect_int("R9", "valid after 4 edges", int'(valid), 1);
    expect_int("R9", "out_q zero amp", out_q, 0);
  endtask

  task automatic run_tone(string req, logic [31:0] t, logic signed [23:0] f,
                          logic signed [15:0] p, logic [15:0] a, int nsamp);
    logic [31:0] teff, ph;
    do_reset();
    tune = t; fm_ofs = f; pm_ofs = p; amp = a; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    tune = ~t; fm_ofs = ~f; pm_ofs = ~p; amp = ~a;
    teff = t + 32'(f);
    repeat (5) @(negedge clk);
    for (int k = 6; k < 6 + nsamp; k++) begin
      @(negedge clk);
      ph = teff * 32'(k - 5) + {p, 16'h0000};
      check_phase({req, "/R4"}, ph, a);
    end
    expect_int(req, "valid", int'(valid), 1);
  endtask

  task automatic test_zero_amp();
    run_tone("R7", 32'h0500_0000, '0, '0, 16'h0000, 8);
    expect_int("R7", "out_i exact zero", out_i, 0);
    expect_int("R7", "out_q exact zero", out_q, 0);
  endtask

  task automatic test_retune();
    logic [31:0] t1, t2, ph;
    t1 = 32'h0300_0000; t2 = 32'h1100_0000;
    do_reset();
    tune = t1; amp = 16'hF000; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (10) @(negedge clk);
    tune = t2; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      if (k <= 5) ph = t1 * 32'(11 + k - 5);
      else        ph = t1 * 32'd11 + t2 * 32'(k - 5);
      check_phase("R8", ph, 16'hF000);
    end
  endtask

  initial begin
    test_reset_valid();
    run_tone("R1", 32'h0280_0000, '0, '0, 16'hFFFF, 40);
    run_tone("R1_wrap", 32'hC100_0000, '0, '0, 16'h8000, 30);
    run_tone("R5", 32'h0100_0000, -24'sd4194304, '0, 16'hC000, 30);
    run_tone("R6", 32'h0400_0000, '0, 16'sh4000, 16'h4000, 20);
    run_tone("R6_neg", 32'h0000_0000, '0, -16'sh2345, 16'hFFFF, 4);
    run_tone("R7_half", 32'h0700_0000, '0, '0, 16'h8000, 20);
    test_zero_amp();
    test_retune();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule